// File: doc/BRIEF.md
# Address-Triggered ROM Bank Mapper

This block widens a 21-bit processor address into a 22-bit physical ROM address, so that a cartridge larger than the processor's native ROM space can be reached. The ROM window has two 512 KB halves. The lower half always shows the first 512 KB page of the ROM. The upper half shows a page chosen by a 2-bit bank register.

Software changes the bank by writing to a special address. The bank number comes from the two lowest address bits of that write, and the write data plays no part. The mapper takes that write for itself and holds it back from the rest of the bus decode. All other writes pass through untouched. The page chosen for the upper half is offset by one, so bank 0 shows the second physical page, just above the fixed page.

Top module: `rom_bank_mapper`

## Requirements
- R1: After a synchronous reset the bank register holds 0, so a read at 0x80000 gives physical address 0x080000.
- R2: A write (`cpu_wr`=1) whose address satisfies `(cpu_addr & 0x1FFC) == 0x1FF0` raises `map_claim` in the same cycle. Only bits 12:0 are compared, so the upper address bits do not affect the match.
- R3: A claimed write loads `cpu_addr[1:0]` into the bank register at the clock edge that ends the write cycle.
- R4: When `cpu_wr` is 1 and the address does not match, `wr_pass` equals 1 and `map_claim` equals 0. A claimed write drives `wr_pass` to 0. Neither a non-matching write nor a read at the special address changes the bank.
- R5: For an address below 0x80000, `rom_addr` equals the address, whatever bank is selected.
- R6: For an address from 0x80000 to 0xFFFFF, `rom_addr` equals (bank+1)·0x80000 + (address − 0x80000). Bank 0 starts at 0x080000 and bank 3 at 0x200000.
- R7: A new bank is used from the cycle after the claiming write. A claimed write whose own address lies in the upper window is translated with the old bank during that cycle.
- R8: `rom_hit` is 1 exactly when the address is below 0x100000. Above that, `rom_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 21 | Processor address |
| cpu_wr | input | 1 | Write strobe for the current cycle |
| rom_addr | output | 22 | Physical ROM address |
| rom_hit | output | 1 | Address lies inside the ROM window |
| map_claim | output | 1 | The mapper has taken this write |
| wr_pass | output | 1 | Write strobe passed on to the other decoders |

## Verification
The hardest case to create is a bank-switch write whose own address lies in the upper window. In that one cycle, the translation must still use the old bank while the register is loading the new one. The stimulus creates this case with special addresses whose high bits are set, such as 0x0F1FF1 and 0x0BFFF2. It also uses a random mix weighted toward special addresses carrying random high bits. As a result, bank changes often land on cycles that read the switchable half, and the check compares every cycle against a model that updates its bank only after the edge.

// File: rtl/rbm_pkg.sv
package rbm_pkg;
   typedef enum logic [1:0] {
      WIN_FIXED  = 2'd0,
      WIN_SWITCH = 2'd1,
      WIN_NONE   = 2'd2
   } win_e;
endpackage

// File: rtl/rbm_hit_dec.sv
module rbm_hit_dec #(
   parameter int          CPU_AW  = 21,
   parameter int          MATCH_W = 13,
   parameter logic [12:0] MASK    = 13'h1FFC,
   parameter logic [12:0] VALUE   = 13'h1FF0
) (
   input  logic [CPU_AW-1:0] addr,
   input  logic              wr,
   output logic              claim
);
   logic [MATCH_W-1:0] bit_ok;

   generate
      for (genvar i = 0; i < MATCH_W; i++) begin : g_bit
         if (MASK[i]) begin : g_cmp
            assign bit_ok[i] = (addr[i] == VALUE[i]);
         end else begin : g_free
            assign bit_ok[i] = 1'b1;
         end
      end
   endgenerate

   assign claim = wr & (&bit_ok);
endmodule

// File: rtl/rbm_bank_reg.sv
module rbm_bank_reg #(
   parameter int BANK_W = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [BANK_W-1:0] nxt,
   output logic [BANK_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst)       q <= '0;
      else if (load) q <= nxt;
   end
endmodule

// File: rtl/rbm_xlate.sv
module rbm_xlate
   import rbm_pkg::*;
#(
   parameter int CPU_AW    = 21,
   parameter int ROM_AW    = 22,
   parameter int PAGE_AW   = 19,
   parameter int BANK_W    = 2,
   parameter int BASE_PAGE = 1
) (
   input  logic [CPU_AW-1:0] addr,
   input  logic [BANK_W-1:0] bank,
   output logic [ROM_AW-1:0] rom_addr,
   output logic              hit
);
   localparam int PG_W  = ROM_AW - PAGE_AW;
   localparam int SEL_W = CPU_AW - PAGE_AW;

   win_e              win;
   logic [PG_W-1:0]   page;
   logic [SEL_W-1:0]  sel;

   assign sel  = addr[CPU_AW-1:PAGE_AW];
   assign page = PG_W'(bank) + PG_W'(BASE_PAGE);

   always_comb begin
      if (sel == SEL_W'(0))      win = WIN_FIXED;
      else if (sel == SEL_W'(1)) win = WIN_SWITCH;
      else                       win = WIN_NONE;
   end

   always_comb begin
      unique case (win)
         WIN_FIXED:  rom_addr = {PG_W'(0), addr[PAGE_AW-1:0]};
         WIN_SWITCH: rom_addr = {page, addr[PAGE_AW-1:0]};
         default:    rom_addr = '0;
      endcase
   end

   assign hit = (win != WIN_NONE);
endmodule

// File: rtl/rom_bank_mapper.sv
module rom_bank_mapper #(
   parameter int          CPU_AW     = 21,
   parameter int          ROM_AW     = 22,
   parameter int          PAGE_AW    = 19,
   parameter int          BANK_W     = 2,
   parameter int          BASE_PAGE  = 1,
   parameter int          MATCH_W    = 13,
   parameter logic [12:0] MATCH_MASK = 13'h1FFC,
   parameter logic [12:0] MATCH_VAL  = 13'h1FF0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [CPU_AW-1:0] cpu_addr,
   input  logic              cpu_wr,
   output logic [ROM_AW-1:0] rom_addr,
   output logic              rom_hit,
   output logic              map_claim,
   output logic              wr_pass
);
   localparam int TOP_PAGE = (1 << BANK_W) - 1 + BASE_PAGE;

   generate
      if (PAGE_AW + 1 >= CPU_AW) begin : g_bad_cpu
         initial $fatal(1, "cpu address too narrow for two windows");
      end
      if (TOP_PAGE >= (1 << (ROM_AW - PAGE_AW))) begin : g_bad_rom
         initial $fatal(1, "rom address cannot hold highest page");
      end
      if (MATCH_MASK[BANK_W-1:0] != '0) begin : g_bad_mask
         initial $fatal(1, "bank field bits must be outside the match mask");
      end
      if ((MATCH_VAL & ~MATCH_MASK) != '0) begin : g_bad_val
         initial $fatal(1, "match value has bits outside the mask");
      end
      if (MATCH_W > CPU_AW || MATCH_W > 13) begin : g_bad_mw
         initial $fatal(1, "match width out of range");
      end
   endgenerate

   logic [BANK_W-1:0] bank_q;

   rbm_hit_dec #(
      .CPU_AW (CPU_AW),
      .MATCH_W(MATCH_W),
      .MASK   (MATCH_MASK),
      .VALUE  (MATCH_VAL)
   ) u_dec (
      .addr (cpu_addr),
      .wr   (cpu_wr),
      .claim(map_claim)
   );

   rbm_bank_reg #(
      .BANK_W(BANK_W)
   ) u_bank (
      .clk (clk),
      .rst (rst),
      .load(map_claim),
      .nxt (cpu_addr[BANK_W-1:0]),
      .q   (bank_q)
   );

   rbm_xlate #(
      .CPU_AW   (CPU_AW),
      .ROM_AW   (ROM_AW),
      .PAGE_AW  (PAGE_AW),
      .BANK_W   (BANK_W),
      .BASE_PAGE(BASE_PAGE)
   ) u_xl (
      .addr    (cpu_addr),
      .bank    (bank_q),
      .rom_addr(rom_addr),
      .hit     (rom_hit)
   );

   assign wr_pass = cpu_wr & ~map_claim;
endmodule

// File: rtl/rom_bank_mapper_chk.sv
module rom_bank_mapper_chk #(
   parameter int CPU_AW    = 21,
   parameter int ROM_AW    = 22,
   parameter int PAGE_AW   = 19,
   parameter int BANK_W    = 2,
   parameter int BASE_PAGE = 1
) (
   input logic              clk,
   input logic              rst,
   input logic [CPU_AW-1:0] cpu_addr,
   input logic              cpu_wr,
   input logic [ROM_AW-1:0] rom_addr,
   input logic              rom_hit,
   input logic              map_claim,
   input logic              wr_pass,
   input logic [BANK_W-1:0] bank_q
);
   localparam int PG_W  = ROM_AW - PAGE_AW;
   localparam int SEL_W = CPU_AW - PAGE_AW;

   // R1
   reset_bank_zero_chk: assert property (@(posedge clk) rst |=> bank_q == '0);

   // R2
   claim_needs_wr_chk: assert property (@(posedge clk) disable iff (rst)
      map_claim |-> cpu_wr && !wr_pass);

   // R3
   bank_load_chk: assert property (@(posedge clk) disable iff (rst)
      map_claim |=> bank_q == $past(cpu_addr[BANK_W-1:0]));

   // R4
   bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !map_claim |=> $stable(bank_q));

   // R4
   pass_when_unclaimed_chk: assert property (@(posedge clk) disable iff (rst)
      (cpu_wr && !map_claim) |-> wr_pass);

   // R5
   fixed_window_chk: assert property (@(posedge clk) disable iff (rst)
      (cpu_addr[CPU_AW-1:PAGE_AW] == SEL_W'(0)) |->
         (rom_addr == ROM_AW'(cpu_addr) && rom_hit));

   // R6
   switch_window_chk: assert property (@(posedge clk) disable iff (rst)
      (cpu_addr[CPU_AW-1:PAGE_AW] == SEL_W'(1)) |->
         (rom_addr[ROM_AW-1:PAGE_AW] == PG_W'(bank_q) + PG_W'(BASE_PAGE)
          && rom_addr[PAGE_AW-1:0] == cpu_addr[PAGE_AW-1:0] && rom_hit));

   // R8
   outside_window_chk: assert property (@(posedge clk) disable iff (rst)
      (cpu_addr[CPU_AW-1:PAGE_AW] > SEL_W'(1)) |-> (!rom_hit && rom_addr == '0));
endmodule

bind rom_bank_mapper rom_bank_mapper_chk #(
   .CPU_AW   (CPU_AW),
   .ROM_AW   (ROM_AW),
   .PAGE_AW  (PAGE_AW),
   .BANK_W   (BANK_W),
   .BASE_PAGE(BASE_PAGE)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .cpu_addr (cpu_addr),
   .cpu_wr   (cpu_wr),
   .rom_addr (rom_addr),
   .rom_hit  (rom_hit),
   .map_claim(map_claim),
   .wr_pass  (wr_pass),
   .bank_q   (bank_q)
);

// File: tb/sim_rom_bank_mapper.sv
`timescale 1ns/1ps
module sim_rom_bank_mapper;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [20:0] cpu_addr = '0;
   logic        cpu_wr = 1'b0;
   logic [21:0] rom_addr;
   logic        rom_hit;
   logic        map_claim;
   logic        wr_pass;

   int n_run  = 0;
   int n_fail = 0;
   int m_bank = 0;
   bit done   = 0;

   always #2.5 clk = ~clk;

   rom_bank_mapper u0 (
      .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
      .rom_addr(rom_addr), .rom_hit(rom_hit),
      .map_claim(map_claim), .wr_pass(wr_pass)
   );

   function automatic int exp_rom(int a, int b);
      if (a < 'h80000)  return a;
      if (a < 'h100000) return (b + 1) * 'h80000 + (a - 'h80000);
      return 0;
   endfunction

   function automatic bit is_magic(int a);
      return (a % 'h2000) >= 'h1FF0 && (a % 'h2000) <= 'h1FF3;
   endfunction

   task automatic chk(string req, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // one bus cycle: drive at negedge, check, then let the model take the edge
   task automatic cyc(int a, bit w);
      bit mg;
      @(negedge clk);
      cpu_addr = 21'(a);
      cpu_wr   = w;
      #1;
      mg = w && is_magic(a);
      chk(mg ? "R2" : "R4", int'(map_claim), int'(mg));
      chk("R4", int'(wr_pass), int'(w && !mg));
      chk("R8", int'(rom_hit), int'(a < 'h100000));
      if (a < 'h80000)       chk("R5", int'(rom_addr), exp_rom(a, m_bank));
      else if (a < 'h100000) chk("R6", int'(rom_addr), exp_rom(a, m_bank));
      else                   chk("R8", int'(rom_addr), 0);
      @(posedge clk);
      if (mg) m_bank = a % 4;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      // R1 bank reset to zero
      cyc('h80000, 0);
      chk("R1", int'(rom_addr), 'h80000);
      cyc('h00123, 0);
      cyc('h7FFFF, 0);
      cyc('hFFFFF, 0);
      cyc('h100000, 0);
      cyc('h1FFFFF, 1);
      // R3 load bank 3 via low magic address
      cyc('h01FF3, 1);
      cyc('h80010, 0);
      chk("R3", int'(rom_addr), 'h200010);
      // R4 read of magic address does not switch
      cyc('h01FF1, 0);
      cyc('h80000, 0);
      chk("R4", int'(rom_addr), 'h200000);
      // R4 near-miss write (0x1FF4) passes and keeps the bank
      cyc('h01FF4, 1);
      cyc('hC0000, 0);
      chk("R4", int'(rom_addr), 'h240000);
      // R7 magic write in upper window uses old bank this cycle
      cyc('h0F1FF1, 1);
      chk("R7", int'(rom_addr), 'h200000 + 'h71FF1);
      cyc('h0F1FF1, 0);
      chk("R7", int'(rom_addr), 'h100000 + 'h71FF1);
      // R2 upper bits ignored in the match
      cyc('h1FFFF2, 1);
      cyc('h0BFFF0, 1);
      chk("R7", int'(rom_addr), 'h180000 + 'h3FFF0);
      cyc('h80000, 0);
      chk("R6", int'(rom_addr), 'h80000);
      // R5 lower window unaffected by bank
      cyc('h01FF2, 1);
      cyc('h40000, 0);
      chk("R5", int'(rom_addr), 'h40000);
      // mixed traffic
      for (int i = 0; i < 400; i++) begin
         int a;
         int k;
         k = $urandom_range(0, 3);
         case (k)
            0: a = ($urandom_range(0, 255) * 'h2000) + 'h1FF0 + $urandom_range(0, 3);
            1: a = $urandom_range(0, 'h7FFFF);
            2: a = $urandom_range('h80000, 'hFFFFF);
            default: a = $urandom_range('h100000, 'h1FFFFF);
         endcase
         cyc(a, 1'($urandom_range(0, 1)));
      end
      // R1 reset again returns to bank 0
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      m_bank = 0;
      @(negedge clk);
      rst = 1'b0;
      cyc('h90000, 0);
      chk("R1", int'(rom_addr), 'h90000);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule